// File: doc/BRIEF.md
# Serial ADC Host Reader

This block is the host side of a link to a 10-bit serial converter that runs on an external conversion clock. On a start request it pulls chip-select low while the serial clock is low, which puts the converter in external-clock mode. It then waits out the converter's wake-up time and produces sixteen clock cycles with the clock idling low. On each rising edge it samples the converter's data line, most significant bit first.

When the sixteenth bit is in, the block splits the frame into its fields. It checks that the leading header bits are all ones and offers the channel flag, the 10-bit result and the two sub-bits on a valid/ready output. It raises chip-select after the final falling clock edge and keeps it high for a recovery time before another read can begin. All timing is set by parameters counted in system-clock cycles. These are the clock divider, a minimum clock phase in nanoseconds, the wake-up wait and the recovery wait.

Top module: `adc_frame_reader`

## Requirements
- R1: `cs_n_o` falls only in a cycle where `sclk_o` is low, and `sclk_o` is low whenever `cs_n_o` is high.
- R2: The first rising edge of `sclk_o` after `cs_n_o` falls comes no earlier than `WAKE_CYC` system cycles after the fall.
- R3: Each frame has exactly 16 rising and 16 falling edges of `sclk_o`. `cs_n_o` rises only after the 16th falling edge, with `sclk_o` low.
- R4: Every high phase and every low phase of `sclk_o` between clock pulses lasts exactly PHASE cycles. PHASE = max(ceil(`SCLK_DIV`/2), ceil(`MIN_PHASE_NS`/`CLK_PERIOD_NS`)).
- R5: `sdi_i` is sampled on each rising edge of `sclk_o`, first bit first, into a 16-bit frame. Frame bits 15..13 are the header, bit 12 is `out_chan_o`, bits 11..2 are `out_data_o` (bit 11 is the MSB) and bits 1..0 are `out_sub_o`.
- R6: `out_hdr_err_o` is 1 when any of frame bits 15..13 is 0 and is 0 when all three are 1. A frame with a bad header is still delivered with its fields.
- R7: Once `out_valid_o` is 1 it stays 1, with all output fields unchanged, until a cycle with `out_ready_i` high. It drops in the cycle after that.
- R8: Between frames `cs_n_o` stays high for at least `RECOV_CYC` cycles, and `start_ready_o` is 0 while the recovery time runs.
- R9: A pulse on `start_i` starts a frame (`cs_n_o` low in the next cycle) only when `start_ready_o` is 1. `start_ready_o` is 1 only when the block is idle and no result is waiting. Any other start pulse is ignored.
- R10: After reset `cs_n_o` = 1, `sclk_o` = 0, `out_valid_o` = 0 and `start_ready_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to read one frame |
| start_ready_o | output | 1 | A start request would be accepted now |
| cs_n_o | output | 1 | Active-low converter select |
| sclk_o | output | 1 | Serial clock to the converter, idles low |
| sdi_i | input | 1 | Serial data from the converter |
| out_valid_o | output | 1 | Result available |
| out_ready_i | input | 1 | Consumer takes the result |
| out_chan_o | output | 1 | Channel flag from the frame |
| out_data_o | output | DATA_W | Conversion result |
| out_sub_o | output | SUB_W | Sub-LSB bits |
| out_hdr_err_o | output | 1 | Header bits were not all ones |

## Verification
The hardest cases to reach from the ports are start requests that land where they must be ignored. One kind arrives while the wake-up wait is running. The other arrives after a frame has ended while its result still sits unconsumed. The bench fires start pulses a few cycles into selected frames and while it deliberately holds `out_ready_i` low. It then counts chip-select falls and checks that chip-select stays high. A converter model in the bench serves every 10-bit code in turn, and a spread of frames carries corrupted headers to exercise the error flag.

// File: rtl/afr_pkg.sv
package afr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WAKE   = 3'd1,
    ST_SCK_LO = 3'd2,
    ST_SCK_HI = 3'd3,
    ST_TAIL   = 3'd4,
    ST_RECOV  = 3'd5
  } afr_state_e;

  function automatic int afr_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int afr_ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/afr_phase_timer.sv
module afr_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = len_i - CNT_W'(1);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/afr_frame_shift.sv
module afr_frame_shift #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               shift_i,
  input  logic               bit_i,
  output logic [FRAME_W-1:0] frame_o
);

  logic [FRAME_W-1:0] sr_q, sr_d;
  logic               sr_en;

  assign sr_en = clr_i | shift_i;

  always_comb begin
    if (clr_i) begin
      sr_d = '0;
    end else begin
      sr_d = {sr_q[FRAME_W-2:0], bit_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (sr_en) begin
      sr_q <= sr_d;
    end
  end

  assign frame_o = sr_q;

endmodule

// File: rtl/afr_result_hold.sv
module afr_result_hold #(
  parameter int HDR_W  = 3,
  parameter int DATA_W = 10,
  parameter int SUB_W  = 2,
  localparam int FRAME_W = HDR_W + 1 + DATA_W + SUB_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               ready_i,
  output logic               valid_o,
  output logic               chan_o,
  output logic [DATA_W-1:0]  data_o,
  output logic [SUB_W-1:0]   sub_o,
  output logic               hdr_err_o
);

  localparam int CHAN_POS = DATA_W + SUB_W;

  logic [HDR_W-1:0]  hdr_field;
  logic              valid_q, valid_d;
  logic              chan_q;
  logic [DATA_W-1:0] data_q;
  logic [SUB_W-1:0]  sub_q;
  logic              err_q;

  assign hdr_field = frame_i[FRAME_W-1 -: HDR_W];

  always_comb begin
    valid_d = valid_q;
    if (push_i) begin
      valid_d = 1'b1;
    end else if (valid_q && ready_i) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= 1'b0;
      data_q <= '0;
      sub_q  <= '0;
      err_q  <= 1'b0;
    end else if (push_i) begin
      chan_q <= frame_i[CHAN_POS];
      data_q <= frame_i[SUB_W +: DATA_W];
      sub_q  <= frame_i[SUB_W-1:0];
      err_q  <= ~(&hdr_field);
    end
  end

  assign valid_o   = valid_q;
  assign chan_o    = chan_q;
  assign data_o    = data_q;
  assign sub_o     = sub_q;
  assign hdr_err_o = err_q;

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int CLK_PERIOD_NS = 8,
  parameter int SCLK_DIV      = 60,
  parameter int MIN_PHASE_NS  = 215,
  parameter int WAKE_CYC      = 313,
  parameter int RECOV_CYC     = 8,
  parameter int HDR_W         = 3,
  parameter int DATA_W        = 10,
  parameter int SUB_W         = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              start_ready_o,
  output logic              cs_n_o,
  output logic              sclk_o,
  input  logic              sdi_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_chan_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [SUB_W-1:0]  out_sub_o,
  output logic              out_hdr_err_o
);

  import afr_pkg::*;

  localparam int FRAME_W   = HDR_W + 1 + DATA_W + SUB_W;
  localparam int PHASE_CYC = afr_max(afr_ceil_div(SCLK_DIV, 2),
                                     afr_ceil_div(MIN_PHASE_NS, CLK_PERIOD_NS));
  localparam int CNT_MAX   = afr_max(afr_max(WAKE_CYC, RECOV_CYC), PHASE_CYC);
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam int BIT_W     = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] WAKE_LEN  = CNT_W'(WAKE_CYC);
  localparam logic [CNT_W-1:0] PHASE_LEN = CNT_W'(PHASE_CYC);
  localparam logic [CNT_W-1:0] RECOV_LEN = CNT_W'(RECOV_CYC);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(FRAME_W - 1);

  afr_state_e         state_q, state_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic               cs_n_q, cs_n_d;
  logic               sclk_q, sclk_d;
  logic               tmr_load;
  logic [CNT_W-1:0]   tmr_len;
  logic               tmr_done;
  logic               sh_clr;
  logic               sh_en;
  logic               push;
  logic [FRAME_W-1:0] frame;
  logic               accept;

  assign start_ready_o = (state_q == ST_IDLE) && !out_valid_o;
  assign accept        = start_i && start_ready_o;

  // sequencer next-state
  always_comb begin
    state_d  = state_q;
    bit_d    = bit_q;
    tmr_load = 1'b0;
    tmr_len  = PHASE_LEN;
    sh_clr   = 1'b0;
    sh_en    = 1'b0;
    push     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d  = ST_WAKE;
          tmr_load = 1'b1;
          tmr_len  = WAKE_LEN;
          sh_clr   = 1'b1;
          bit_d    = '0;
        end
      end
      ST_WAKE: begin
        if (tmr_done) begin
          state_d  = ST_SCK_LO;
          tmr_load = 1'b1;
        end
      end
      ST_SCK_LO: begin
        if (tmr_done) begin
          state_d  = ST_SCK_HI;
          tmr_load = 1'b1;
          sh_en    = 1'b1;
        end
      end
      ST_SCK_HI: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          if (bit_q == LAST_BIT) begin
            state_d = ST_TAIL;
            push    = 1'b1;
          end else begin
            state_d = ST_SCK_LO;
            bit_d   = bit_q + BIT_W'(1);
          end
        end
      end
      ST_TAIL: begin
        if (tmr_done) begin
          state_d  = ST_RECOV;
          tmr_load = 1'b1;
          tmr_len  = RECOV_LEN;
        end
      end
      ST_RECOV: begin
        if (tmr_done) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cs_n_d = !((state_d == ST_WAKE) || (state_d == ST_SCK_LO) ||
               (state_d == ST_SCK_HI) || (state_d == ST_TAIL));
    sclk_d = (state_d == ST_SCK_HI);
  end

  // sequencer registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      cs_n_q  <= cs_n_d;
      sclk_q  <= sclk_d;
    end
  end

  assign cs_n_o = cs_n_q;
  assign sclk_o = sclk_q;

  afr_phase_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .done_o (tmr_done)
  );

  afr_frame_shift #(
    .FRAME_W (FRAME_W)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (sh_clr),
    .shift_i (sh_en),
    .bit_i   (sdi_i),
    .frame_o (frame)
  );

  afr_result_hold #(
    .HDR_W  (HDR_W),
    .DATA_W (DATA_W),
    .SUB_W  (SUB_W)
  ) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (push),
    .frame_i   (frame),
    .ready_i   (out_ready_i),
    .valid_o   (out_valid_o),
    .chan_o    (out_chan_o),
    .data_o    (out_data_o),
    .sub_o     (out_sub_o),
    .hdr_err_o (out_hdr_err_o)
  );

endmodule

// File: rtl/afr_checker.sv
module afr_checker #(
  parameter int WAKE_CYC  = 313,
  parameter int RECOV_CYC = 8,
  parameter int PHASE_CYC = 30,
  parameter int DATA_W    = 10,
  parameter int SUB_W     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              start_ready_o,
  input logic              cs_n_o,
  input logic              sclk_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic              out_chan_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic [SUB_W-1:0]  out_sub_o,
  input logic              out_hdr_err_o
);

  localparam int CAP = 1 << 20;

  logic prev_sclk;
  int   run_len;
  int   low_len;
  int   hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sclk <= 1'b0;
      run_len   <= 0;
      low_len   <= 0;
      hi_len    <= RECOV_CYC;
    end else begin
      prev_sclk <= sclk_o;
      if (sclk_o != prev_sclk) run_len <= 1;
      else if (run_len < CAP)  run_len <= run_len + 1;
      if (cs_n_o)              low_len <= 0;
      else if (low_len < CAP)  low_len <= low_len + 1;
      if (!cs_n_o)             hi_len  <= 0;
      else if (hi_len < CAP)   hi_len  <= hi_len + 1;
    end
  end

  p_cs_fall_sclk_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> !sclk_o);

  p_idle_sclk_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);

  p_wake_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> low_len >= WAKE_CYC);

  p_cs_rise_sclk_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> !sclk_o);

  p_phase_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o != prev_sclk) && !cs_n_o |-> run_len >= PHASE_CYC);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_chan_o) &&
      $stable(out_data_o) && $stable(out_sub_o) && $stable(out_hdr_err_o));

  p_recovery_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> hi_len >= RECOV_CYC);

  p_start_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && start_ready_o |=> !cs_n_o);

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o && !(start_i && start_ready_o) |=> cs_n_o);

endmodule

bind adc_frame_reader afr_checker #(
  .WAKE_CYC  (WAKE_CYC),
  .RECOV_CYC (RECOV_CYC),
  .PHASE_CYC (PHASE_CYC),
  .DATA_W    (DATA_W),
  .SUB_W     (SUB_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .start_ready_o (start_ready_o),
  .cs_n_o        (cs_n_o),
  .sclk_o        (sclk_o),
  .out_valid_o   (out_valid_o),
  .out_ready_i   (out_ready_i),
  .out_chan_o    (out_chan_o),
  .out_data_o    (out_data_o),
  .out_sub_o     (out_sub_o),
  .out_hdr_err_o (out_hdr_err_o)
);

// File: tb/adc_frame_reader_test.sv
`timescale 1ns/1ps
module adc_frame_reader_test;

  localparam int CLK_NS   = 8;
  localparam int DIV      = 4;
  localparam int MINPH_NS = 20;
  localparam int WAKE     = 6;
  localparam int RECOV    = 3;
  localparam int PHASE_A  = (DIV + 1) / 2;
  localparam int PHASE_B  = (MINPH_NS + CLK_NS - 1) / CLK_NS;
  localparam int PHASE    = (PHASE_A > PHASE_B) ? PHASE_A : PHASE_B;
  localparam int LIMIT    = 195000;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic       start_ready_o;
  logic       cs_n_o;
  logic       sclk_o;
  logic       sdi;
  logic       out_valid_o;
  logic       out_ready_i;
  logic       out_chan_o;
  logic [9:0] out_data_o;
  logic [1:0] out_sub_o;
  logic       out_hdr_err_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic timeout = 1'b0;

  adc_frame_reader #(
    .CLK_PERIOD_NS (CLK_NS),
    .SCLK_DIV      (DIV),
    .MIN_PHASE_NS  (MINPH_NS),
    .WAKE_CYC      (WAKE),
    .RECOV_CYC     (RECOV)
  ) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .start_ready_o (start_ready_o),
    .cs_n_o        (cs_n_o),
    .sclk_o        (sclk_o),
    .sdi_i         (sdi),
    .out_valid_o   (out_valid_o),
    .out_ready_i   (out_ready_i),
    .out_chan_o    (out_chan_o),
    .out_data_o    (out_data_o),
    .out_sub_o     (out_sub_o),
    .out_hdr_err_o (out_hdr_err_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= LIMIT) timeout <= 1'b1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // converter model: data changes on falling SCLK, first bit at select
  logic [15:0] tx_frame;
  int bidx;
  initial begin sdi = 1'b0; tx_frame = '0; bidx = 0; end
  always @(negedge cs_n_o) if (cs_n_o === 1'b0) begin
    bidx = 15;
    sdi  = tx_frame[15];
  end
  always @(negedge sclk_o) if (cs_n_o === 1'b0 && rst_n === 1'b1) begin
    bidx = bidx - 1;
    sdi  = (bidx >= 0) ? tx_frame[bidx[3:0]] : 1'b0;
  end
  always @(posedge cs_n_o) sdi = 1'b0;

  // port monitor, sampled mid-cycle
  logic p_cs, p_sclk;
  int rises, falls, run, low_cnt, hi_cnt, cs_falls, idle_bad;
  initial begin
    p_cs = 1'b1; p_sclk = 1'b0; rises = 0; falls = 0; run = 0;
    low_cnt = 0; hi_cnt = 1000; cs_falls = 0; idle_bad = 0;
  end

  always @(negedge clk) if (rst_n) begin
    if (cs_n_o && sclk_o) idle_bad++;
    if (!cs_n_o && p_cs) begin
      check(sclk_o == 1'b0, "R1 sclk at select fall", int'(sclk_o), 0);
      check(hi_cnt >= RECOV, "R8 select high time", hi_cnt, RECOV);
      cs_falls++; rises = 0; falls = 0; low_cnt = 1; run = 1;
    end else if (cs_n_o && !p_cs) begin
      check(sclk_o == 1'b0 && falls == 16 && rises == 16, "R3 edges at select rise",
            rises * 100 + falls, 1616);
      check(!start_ready_o, "R8 ready during recovery", int'(start_ready_o), 0);
      hi_cnt = 1;
    end else if (cs_n_o) begin
      hi_cnt++;
    end else begin
      if (sclk_o && !p_sclk) begin
        rises++;
        if (rises == 1) check(low_cnt >= WAKE, "R2 wake wait", low_cnt, WAKE);
        else            check(run == PHASE, "R4 low phase", run, PHASE);
        run = 1;
      end else if (!sclk_o && p_sclk) begin
        falls++;
        check(run == PHASE, "R4 high phase", run, PHASE);
        run = 1;
      end else begin
        run++;
      end
      low_cnt++;
    end
    p_cs   = cs_n_o;
    p_sclk = sclk_o;
  end

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; out_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n_o === 1'b1, "R10 cs_n after reset", int'(cs_n_o), 1);
    check(sclk_o === 1'b0, "R10 sclk after reset", int'(sclk_o), 0);
    check(out_valid_o === 1'b0, "R10 valid after reset", int'(out_valid_o), 0);
    check(start_ready_o === 1'b1, "R10 ready after reset", int'(start_ready_o), 1);

    for (int code = 0; code < 1024; code++) begin
      logic [2:0] hdr;
      logic       ch;
      logic [1:0] sb;
      logic [9:0] dv;
      int         exp_falls;
      if (timeout) break;
      dv  = 10'(code);
      ch  = dv[0] ^ dv[5];
      sb  = dv[2:1] ^ 2'b01;
      hdr = ((code % 64) == 5) ? 3'((code / 64) % 7) : 3'b111;
      while (!start_ready_o && !timeout) @(negedge clk);
      tx_frame  = {hdr, ch, dv, sb};
      exp_falls = cs_falls + 1;
      pulse_start();
      if ((code % 16) == 7) begin
        repeat (2) @(negedge clk);
        pulse_start(); // R9: ignored while the wake wait runs
      end
      while (!out_valid_o && !timeout) @(negedge clk);
      check(out_data_o == dv, "R5 data", int'(out_data_o), int'(dv));
      check(out_chan_o == ch && out_sub_o == sb, "R5 chan/sub",
            int'({out_chan_o, out_sub_o}), int'({ch, sb}));
      check(out_hdr_err_o == (hdr != 3'b111), "R6 header flag",
            int'(out_hdr_err_o), int'(hdr != 3'b111));
      if ((code % 8) == 3) begin
        repeat (5) @(negedge clk);
        check(out_valid_o && out_data_o == dv && out_chan_o == ch && out_sub_o == sb,
              "R7 hold while stalled", int'(out_data_o), int'(dv));
      end
      if ((code % 16) == 11) begin
        repeat (RECOV + 4) @(negedge clk);
        check(!start_ready_o, "R9 ready with result pending", int'(start_ready_o), 0);
        pulse_start();
        @(negedge clk);
        check(cs_n_o == 1'b1, "R9 start ignored with result pending", int'(cs_n_o), 1);
      end
      out_ready_i = 1'b1;
      @(negedge clk);
      out_ready_i = 1'b0;
      check(!out_valid_o, "R7 valid drops after ready", int'(out_valid_o), 0);
      check(cs_falls == exp_falls, "R9 one frame per accepted start", cs_falls, exp_falls);
    end

    check(idle_bad == 0, "R1 sclk low while deselected", idle_bad, 0);
    if (timeout) check(1'b0, "watchdog", cyc, LIMIT);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule